// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire PHY management bus. It reads and writes 16-bit registers in an Ethernet PHY using clause-22 frames. Software first loads a 16-bit data value when a write is needed. It then writes a command word that holds a 5-bit PHY address, a 5-bit register address, a write-select bit, a 3-bit clock-range code and a busy bit. Writing the command with the busy bit set starts one frame. The block serializes the frame on the data line, which has separate output, output-enable and input pins. It generates the management clock by dividing the system clock, and it clears the busy bit by itself when the frame ends.

The range code selects how far the system clock is divided. The mapping from code to ratio does not rise with the code value. This lets software choose a ratio that keeps the management clock between 1 MHz and 2.5 MHz, which is a clock period between 400 ns and 1 us. For a read, the 16 bits returned by the PHY replace the content of the data register, and that value is valid once busy has dropped.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, mdc, mdioOe and mdioOut are 0 and dataRd is 0.
- R2: A command write with cmdStart=1 while idle sets busy on the next clock edge. Busy then stays high for exactly 64·N clock cycles and clears by itself, where N is the divide ratio.
- R3: The range code sets N as follows: code 0→21, 1→31, 2→8, 3→13, 4→51, 5→62, and codes 6 and 7→62. Each bit period lasts N cycles, with mdc high for floor(N/2) of those cycles.
- R4: Every frame begins with 32 ones, then 01, then opcode 01 for a write or 10 for a read. The 5-bit PHY address follows, then the 5-bit register address, both MSB first. All of these bits are driven with mdioOe=1.
- R5: In a write frame, bits 46–47 are 10 and bits 48–63 are the data register MSB first. mdioOe stays 1 for all 64 bits, and the data register keeps its value.
- R6: In a read frame, mdioOe is 0 for bits 46–63. mdioIn is sampled on the mdc rising edge of bits 48–63, MSB first, into the data register. dataRd holds those 16 bits when busy clears.
- R7: While a frame runs, mdioOut changes only at the clock edge where mdc falls.
- R8: While busy, command writes (including cmdStart) and data writes are ignored. The running frame and the data register are unaffected.
- R9: While idle, mdc is low, mdioOe is 0 and mdioOut is 0.
- R10: A command write with cmdStart=0 does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command register write strobe |
| cmdStart | input | 1 | Busy bit of the written command; 1 starts a frame |
| cmdWrite | input | 1 | 1 = write frame, 0 = read frame |
| cmdRange | input | 3 | Clock-range code |
| cmdPhy | input | 5 | PHY address |
| cmdReg | input | 5 | PHY register address |
| dataWrEn | input | 1 | Data register write strobe |
| dataWrVal | input | 16 | Value for the data register |
| dataRd | output | 16 | Data register contents |
| busy | output | 1 | Busy bit of the command register |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line output value |
| mdioOe | output | 1 | Data line output enable |
| mdioIn | input | 1 | Data line input value |

## Verification
Busy is due one edge after the start command and falls exactly 64·N cycles later. The bench counts busy-high cycles at falling clock edges and compares the count with 64·N for every range code. Frame bits are recorded at the first falling clock edge after each mdc rise, half a cycle after mdc goes high. Because mdioOut settles at the previous mdc fall, the recorded values are stable. The PHY model advances its read bit on the same observation, so the bit for index k is on mdioIn at the edge where the design samples it. dataRd is checked only after busy has been seen low.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int RANGE_W = 3;
  localparam int DIV_W   = 6;

  typedef struct packed {
    logic load;    // latch a new frame and begin
    logic shift;   // advance to next bit at mdc fall
    logic sample;  // capture input bit at mdc rise
  } mdioStb_t;

  function automatic logic [DIV_W-1:0] mdcRatio(input logic [RANGE_W-1:0] code);
    case (code)
      3'd0:    mdcRatio = 6'd21;
      3'd1:    mdcRatio = 6'd31;
      3'd2:    mdcRatio = 6'd8;
      3'd3:    mdcRatio = 6'd13;
      3'd4:    mdcRatio = 6'd51;
      default: mdcRatio = 6'd62;
    endcase
  endfunction

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int FRAME_LEN = 64,
  parameter int TA_IDX    = 46,
  parameter int DATA_IDX  = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [RANGE_W-1:0] rangeQ,
  input  logic               wrQ,
  output logic               busy,
  output logic               mdc,
  output logic               oe,
  output mdioStb_t           stb
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_I   = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] DATA_I = IDX_W'(DATA_IDX);

  logic             busyQ, mdcQ;
  logic [DIV_W-1:0] cnt, ratio, lowLen;
  logic [IDX_W-1:0] bitIdx;
  logic             atRise, atEnd;

  always_comb begin
    ratio  = mdcRatio(rangeQ);
    lowLen = ratio - (ratio >> 1);
    atRise = (cnt == lowLen - DIV_W'(1));
    atEnd  = (cnt == ratio - DIV_W'(1));
    stb.load   = startReq && !busyQ;
    stb.shift  = busyQ && atEnd && (bitIdx != LAST_I);
    stb.sample = busyQ && atRise && !wrQ && (bitIdx >= DATA_I);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      mdcQ   <= 1'b0;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (stb.load) begin
      busyQ  <= 1'b1;
      mdcQ   <= 1'b0;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (busyQ) begin
      if (atEnd) begin
        cnt  <= '0;
        mdcQ <= 1'b0;
        if (bitIdx == LAST_I) busyQ <= 1'b0;
        else                  bitIdx <= bitIdx + IDX_W'(1);
      end else begin
        cnt <= cnt + DIV_W'(1);
        if (atRise) mdcQ <= 1'b1;
      end
    end
  end

  assign busy = busyQ;
  assign mdc  = mdcQ;
  assign oe   = busyQ && (wrQ || (bitIdx < TA_I));

endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int PRE_LEN   = 32,
  parameter int FRAME_LEN = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  mdioStb_t           stb,
  input  logic               busy,
  input  logic               cmdWrEn,
  input  logic               cmdWrite,
  input  logic [RANGE_W-1:0] cmdRange,
  input  logic [ADDR_W-1:0]  cmdPhy,
  input  logic [ADDR_W-1:0]  cmdReg,
  input  logic               dataWrEn,
  input  logic [DATA_W-1:0]  dataWrVal,
  input  logic               mdioIn,
  output logic [RANGE_W-1:0] rangeQ,
  output logic               wrQ,
  output logic               mdioOut,
  output logic [DATA_W-1:0]  dataQ
);
  logic [FRAME_LEN-1:0] txSh, frameInit;
  logic [1:0]           opc, ta;
  logic [DATA_W-1:0]    payload;

  always_comb begin
    opc       = cmdWrite ? 2'b01 : 2'b10;
    ta        = cmdWrite ? 2'b10 : 2'b00;
    payload   = cmdWrite ? dataQ : '0;
    frameInit = {{PRE_LEN{1'b1}}, 2'b01, opc, cmdPhy, cmdReg, ta, payload};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rangeQ <= '0;
      wrQ    <= 1'b0;
      txSh   <= '0;
      dataQ  <= '0;
    end else begin
      if (cmdWrEn && !busy) begin
        rangeQ <= cmdRange;
        wrQ    <= cmdWrite;
      end
      if (stb.load)       txSh <= frameInit;
      else if (stb.shift) txSh <= {txSh[FRAME_LEN-2:0], 1'b0};
      if (dataWrEn && !busy) dataQ <= dataWrVal;
      else if (stb.sample)   dataQ <= {dataQ[DATA_W-2:0], mdioIn};
    end
  end

  assign mdioOut = busy && txSh[FRAME_LEN-1];

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWrEn,
  input  logic               cmdStart,
  input  logic               cmdWrite,
  input  logic [RANGE_W-1:0] cmdRange,
  input  logic [ADDR_W-1:0]  cmdPhy,
  input  logic [ADDR_W-1:0]  cmdReg,
  input  logic               dataWrEn,
  input  logic [DATA_W-1:0]  dataWrVal,
  output logic [DATA_W-1:0]  dataRd,
  output logic               busy,
  output logic               mdc,
  output logic               mdioOut,
  output logic               mdioOe,
  input  logic               mdioIn
);
  localparam int TA_IDX    = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_IDX  = TA_IDX + 2;
  localparam int FRAME_LEN = DATA_IDX + DATA_W;

  mdioStb_t           stb;
  logic [RANGE_W-1:0] rangeQ;
  logic               wrQ;

  mdio_ctrl #(
    .FRAME_LEN(FRAME_LEN), .TA_IDX(TA_IDX), .DATA_IDX(DATA_IDX)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(cmdWrEn && cmdStart),
    .rangeQ(rangeQ), .wrQ(wrQ), .busy(busy), .mdc(mdc), .oe(mdioOe), .stb(stb)
  );

  mdio_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN), .FRAME_LEN(FRAME_LEN)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy),
    .cmdWrEn(cmdWrEn), .cmdWrite(cmdWrite), .cmdRange(cmdRange),
    .cmdPhy(cmdPhy), .cmdReg(cmdReg), .dataWrEn(dataWrEn), .dataWrVal(dataWrVal),
    .mdioIn(mdioIn), .rangeQ(rangeQ), .wrQ(wrQ), .mdioOut(mdioOut), .dataQ(dataRd)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWrEn,
  input logic              cmdStart,
  input logic              busy,
  input logic              mdc,
  input logic              mdioOut,
  input logic              mdioOe,
  input logic [DATA_W-1:0] dataRd
);
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    !busy && cmdWrEn && cmdStart |=> busy); // R2

  AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !(cmdWrEn && cmdStart) |=> !busy); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc && !mdioOe && !mdioOut); // R9

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) && !$stable(mdioOut) |-> $fell(mdc)); // R7

  AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) && !$stable(dataRd) |-> $rose(mdc) && !mdioOe); // R6

  AST_MDC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> busy); // R9

endmodule

bind mdio_master mdio_master_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdStart(cmdStart), .busy(busy),
  .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .dataRd(dataRd)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0, cmdStart = 1'b0, cmdWrite = 1'b0;
  logic [2:0]  cmdRange = '0;
  logic [4:0]  cmdPhy = '0, cmdReg = '0;
  logic        dataWrEn = 1'b0;
  logic [15:0] dataWrVal = '0;
  logic [15:0] dataRd;
  logic        busy, mdc, mdioOut, mdioOe, mdioIn;

  int          nChecks = 0, nFails = 0;
  logic [15:0] rdVal = '0;
  logic [63:0] capOut = '0, capOe = '0;
  int          riseCnt = 0, busyCnt = 0, hiRun = 0, hiLen = 0;
  logic        prevMdc = 1'b0, prevBusy = 1'b0;

  always #2.5 clk = ~clk;

  mdio_master i_mdio_master (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdStart(cmdStart),
    .cmdWrite(cmdWrite), .cmdRange(cmdRange), .cmdPhy(cmdPhy), .cmdReg(cmdReg),
    .dataWrEn(dataWrEn), .dataWrVal(dataWrVal), .dataRd(dataRd), .busy(busy),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // PHY model: bit index = number of mdc rises seen so far in the frame
  always_comb begin
    if (riseCnt >= 48 && riseCnt < 64) mdioIn = rdVal[63 - riseCnt];
    else                               mdioIn = 1'b1;
  end

  always @(negedge clk) begin
    if (!busy) riseCnt <= 0;
    else if (mdc && !prevMdc) begin
      capOut[63 - riseCnt] <= mdioOut;
      capOe[63 - riseCnt]  <= mdioOe;
      riseCnt <= riseCnt + 1;
    end
    if (busy && !prevBusy) busyCnt <= 1;
    else if (busy)         busyCnt <= busyCnt + 1;
    if (mdc) hiRun <= hiRun + 1;
    else begin
      if (prevMdc) hiLen <= hiRun;
      hiRun <= 0;
    end
    prevMdc  <= mdc;
    prevBusy <= busy;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int ratioOf(input int code);
    case (code)
      0: return 21;
      1: return 31;
      2: return 8;
      3: return 13;
      4: return 51;
      default: return 62;
    endcase
  endfunction

  task automatic writeData(input logic [15:0] v);
    @(posedge clk); #1;
    dataWrEn = 1'b1; dataWrVal = v;
    @(posedge clk); #1;
    dataWrEn = 1'b0;
  endtask

  task automatic issueCmd(input bit start, input bit wr, input logic [2:0] code,
                          input logic [4:0] phy, input logic [4:0] rg,
                          input bit alsoData, input logic [15:0] dv);
    @(posedge clk); #1;
    cmdWrEn = 1'b1; cmdStart = start; cmdWrite = wr;
    cmdRange = code; cmdPhy = phy; cmdReg = rg;
    dataWrEn = alsoData; dataWrVal = dv;
    @(posedge clk); #1;
    cmdWrEn = 1'b0; cmdStart = 1'b0; dataWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 8000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic frameCheck(input bit wr, input int code, input logic [4:0] phy,
                            input logic [4:0] rg, input logic [15:0] dv);
    logic [63:0] hdr;
    int n;
    n   = ratioOf(code);
    hdr = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 18'h0};
    check(busyCnt == 64 * n, "R2", "busy length", 64'(busyCnt), 64'(64 * n));
    check(hiLen == n / 2, "R3", "mdc high time", 64'(hiLen), 64'(n / 2));
    check(capOut[63:18] == hdr[63:18] && capOe[63:18] == {46{1'b1}}, "R4",
          "header bits", capOut, hdr);
    if (wr) begin
      check(capOut[17:0] == {2'b10, dv} && capOe[17:0] == {18{1'b1}}, "R5",
            "turnaround and data", {46'h0, capOut[17:0]}, {46'h0, 2'b10, dv});
      check(dataRd == dv, "R5", "data register kept", 64'(dataRd), 64'(dv));
    end else begin
      check(capOe[17:0] == 18'h0, "R6", "released line", {46'h0, capOe[17:0]}, 64'h0);
      check(dataRd == dv, "R6", "read data", 64'(dataRd), 64'(dv));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!busy && !mdc && !mdioOe && !mdioOut && dataRd == 16'h0, "R1", "reset state",
          {44'h0, busy, mdc, mdioOe, mdioOut, dataRd}, 64'h0);

    // R10: command write without busy bit
    issueCmd(1'b0, 1'b1, 3'd2, 5'h03, 5'h04, 1'b0, 16'h0);
    repeat (20) @(negedge clk);
    check(!busy && !mdc, "R10", "no start", {62'h0, busy, mdc}, 64'h0);
    check(!mdioOe && !mdioOut, "R9", "idle line", {62'h0, mdioOe, mdioOut}, 64'h0);

    // Sweep every range code with a write and a read (R2-R6)
    for (int c = 0; c < 8; c++) begin
      logic [4:0]  phy;
      logic [4:0]  rg;
      logic [15:0] wv;
      phy = 5'(c * 3 + 1);
      rg  = 5'(31 - c * 4);
      wv  = 16'h8001 ^ 16'(c * 16'h1357);
      writeData(wv);
      issueCmd(1'b1, 1'b1, 3'(c), phy, rg, 1'b0, 16'h0);
      waitIdle();
      frameCheck(1'b1, c, phy, rg, wv);
      rdVal = 16'hC3A5 ^ 16'(c * 16'h0F11);
      issueCmd(1'b1, 1'b0, 3'(c), ~phy, ~rg, 1'b0, 16'h0);
      waitIdle();
      frameCheck(1'b0, c, ~phy, ~rg, rdVal);
      check(!mdc && !mdioOe, "R9", "idle after frame", {62'h0, mdc, mdioOe}, 64'h0);
    end

    // R8: start and data write while busy are ignored
    writeData(16'hA5C3);
    issueCmd(1'b1, 1'b1, 3'd2, 5'h11, 5'h0A, 1'b0, 16'h0);
    repeat (100) @(negedge clk);
    issueCmd(1'b1, 1'b0, 3'd5, 5'h02, 5'h1F, 1'b1, 16'h1234);
    check(busy == 1'b1, "R8", "still busy", 64'(busy), 64'h1);
    waitIdle();
    check(busyCnt == 64 * 8, "R8", "ratio unchanged", 64'(busyCnt), 64'(512));
    check(capOut == {32'hFFFF_FFFF, 4'b0101, 5'h11, 5'h0A, 2'b10, 16'hA5C3}, "R8",
          "frame unchanged", capOut,
          {32'hFFFF_FFFF, 4'b0101, 5'h11, 5'h0A, 2'b10, 16'hA5C3});
    check(dataRd == 16'hA5C3, "R8", "data unchanged", 64'(dataRd), 64'hA5C3);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule